// File: doc/BRIEF.md
# Sequence-Protected Power-Down Controller

This block holds the power-control register of a small 8-bit microcontroller and decides when the core may enter its clock-stopping sleep state. Software cannot reach that state with a single stray store. It must first write a byte that sets the arm flag. The store of the very next retired instruction must then set the start flag. Both flags clear themselves and always read back as zero. A single store that sets both flags does nothing. Sleep is also refused while the external enable pin is high.

Once the sequence completes, the block raises its oscillator-stop output on the next clock edge. From then on the block is frozen. The clock-out, address-latch strobe and program-store strobe are forced low. The alternate-function outputs keep the values they carried in the cycle of the start store. Register stores are ignored. Only a hardware reset leaves this state, and that reset returns the register to zero.

The block also arbitrates between idle and sleep. Idle is requested either by the register's idle bit or by an external request, and sleep always wins over idle. Every pin is a plain control level. There is no data stream and no handshake at the edge of the block.

Top module: `pdn_ctrl`

## Requirements
- R1: Sleep is entered under the following condition. A retired register store sets bit 1 (arm) and clears bit 6 (start). The next retired instruction is then a register store that sets bit 6 and clears bit 1. The pin `pd_allow_n` must be low at both stores. `osc_stop` rises at the clock edge that retires the second store.
- R2: Any retired instruction between the two stores cancels the arming. This includes an instruction that stores nothing and a store that does not set bit 6. Cycles with `insn_done` low do not count as instructions.
- R3: A single store with both bit 1 and bit 6 set neither arms the sequence nor enters sleep.
- R4: Reading the register returns 0 in bits 1 and 6. Every other bit returns the value last stored.
- R5: While `pd_allow_n` is high, neither an arm store nor a start store has any effect on entry.
- R6: `idle_active` is high when register bit 0 or `idle_req` is high and the block is not asleep. While asleep it is low, so sleep wins when both are requested together.
- R7: Once asleep, `osc_stop` stays high and register stores are ignored until reset.
- R8: While asleep, `clk_out`, `ale_out` and `psen_out` are low. Before that they follow their source inputs.
- R9: While asleep, `alt_out` holds the value `alt_src` had in the cycle the start store retired. Before that it follows `alt_src`.
- R10: Reset clears the register to 0, cancels any arming and drops `osc_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low hardware reset |
| insn_done | input | 1 | An instruction retires this cycle |
| reg_wr_en | input | 1 | The retiring instruction stores the register (valid only with insn_done) |
| reg_wr_data | input | 8 | Byte being stored |
| reg_rd_data | output | 8 | Register read value, flags read as zero |
| pd_allow_n | input | 1 | Sleep enable pin, low permits sleep |
| idle_req | input | 1 | External idle request |
| clk_out_src | input | 1 | Clock-out level before gating |
| ale_src | input | 1 | Address-latch strobe before forcing |
| psen_src | input | 1 | Program-store strobe before forcing |
| alt_src | input | 4 | Alternate-function outputs before holding |
| osc_stop | output | 1 | Oscillator stop, high while asleep |
| idle_active | output | 1 | Idle state granted |
| clk_out | output | 1 | Gated clock-out |
| ale_out | output | 1 | Address-latch strobe, low while asleep |
| psen_out | output | 1 | Program-store strobe, low while asleep |
| alt_out | output | 4 | Alternate-function outputs, held while asleep |

## Verification
The bench builds the block with its default 8-bit register, flags at bits 1 and 6, and four alternate-function lines. With an 8-bit register, every one of the 256 values can be tried in the first store slot and in the second, and every value can be read back. Because of this, the entry rule and the read masking are checked over the full byte space, not only on chosen samples. Directed sequences then cover the two disarming cases, the enable pin, the arbitration with idle, the output freezing and the reset exit.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [1:0] {
    SEQ_OPEN  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_DOWN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pdn_reg_file.sv
module pdn_reg_file #(
  parameter int DATA_W    = 8,
  parameter int ARM_BIT   = 1,
  parameter int START_BIT = 6,
  parameter int IDLE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              freeze,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              idle_bit
);
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << ARM_BIT) | (DATA_W'(1) << START_BIT);

  logic [DATA_W-1:0] store_q;

  // Flag positions carry no storage; all other bits are plain flops.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (FLAG_MASK[b]) begin : g_flag
      assign store_q[b] = 1'b0;
    end else begin : g_data
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               bit_q <= 1'b0;
        else if (commit && !freeze) bit_q <= wdata[b];
      end
      assign store_q[b] = bit_q;
    end
  end

  assign rd_data  = store_q;
  assign idle_bit = store_q[IDLE_BIT];

  AST_FLAGS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[ARM_BIT] == 1'b0) && (rd_data[START_BIT] == 1'b0)); // R4
  AST_FROZEN_REG: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(rd_data)); // R7
endmodule

// File: rtl/pdn_seq_guard.sv
module pdn_seq_guard
  import pdn_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ARM_BIT   = 1,
  parameter int START_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_done,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pin_n,
  output logic              down_o
);
  seq_state_t state_q, state_d;
  logic store_ok, arm_only, start_only;

  assign store_ok   = insn_done && wr_en && !pin_n;
  assign arm_only   = wdata[ARM_BIT] && !wdata[START_BIT];
  assign start_only = wdata[START_BIT] && !wdata[ARM_BIT];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_OPEN: begin
        if (store_ok && arm_only) state_d = SEQ_ARMED;
      end
      SEQ_ARMED: begin
        if (insn_done) begin
          if (store_ok && start_only)    state_d = SEQ_DOWN;
          else if (store_ok && arm_only) state_d = SEQ_ARMED;
          else                           state_d = SEQ_OPEN;
        end
      end
      SEQ_DOWN: state_d = SEQ_DOWN;
      default:  state_d = SEQ_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_OPEN;
    else        state_q <= state_d;
  end

  assign down_o = (state_q == SEQ_DOWN);

  AST_ENTRY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(down_o) |-> ($past(state_q) == SEQ_ARMED)); // R1
  AST_BOTH_SET_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && wr_en && wdata[ARM_BIT] && wdata[START_BIT] && !down_o)
      |=> (!down_o && state_q != SEQ_ARMED)); // R3
  AST_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_n && !down_o) |=> !down_o); // R5
  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    down_o |=> down_o); // R7
endmodule

// File: rtl/pdn_out_hold.sv
module pdn_out_hold #(
  parameter int ALT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             down,
  input  logic             clk_src,
  input  logic             ale_src,
  input  logic             psen_src,
  input  logic [ALT_W-1:0] alt_src,
  output logic             clk_out,
  output logic             ale_out,
  output logic             psen_out,
  output logic [ALT_W-1:0] alt_out
);
  // Each alternate line keeps a shadow of its last pre-sleep value.
  for (genvar i = 0; i < ALT_W; i++) begin : g_alt
    logic hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_q <= 1'b0;
      else if (!down) hold_q <= alt_src[i];
    end
    assign alt_out[i] = down ? hold_q : alt_src[i];
  end

  assign clk_out  = clk_src  && !down;
  assign ale_out  = ale_src  && !down;
  assign psen_out = psen_src && !down;

  AST_STROBES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    down |-> (!clk_out && !ale_out && !psen_out)); // R8
  AST_ALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (down && $past(down)) |-> $stable(alt_out)); // R9
endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl #(
  parameter int DATA_W    = 8,
  parameter int ARM_BIT   = 1,
  parameter int START_BIT = 6,
  parameter int IDLE_BIT  = 0,
  parameter int ALT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_done,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              pd_allow_n,
  input  logic              idle_req,
  input  logic              clk_out_src,
  input  logic              ale_src,
  input  logic              psen_src,
  input  logic [ALT_W-1:0]  alt_src,
  output logic              osc_stop,
  output logic              idle_active,
  output logic              clk_out,
  output logic              ale_out,
  output logic              psen_out,
  output logic [ALT_W-1:0]  alt_out
);
  logic down;
  logic idle_bit;
  logic commit;

  assign commit = insn_done && reg_wr_en;

  pdn_reg_file #(
    .DATA_W(DATA_W), .ARM_BIT(ARM_BIT), .START_BIT(START_BIT), .IDLE_BIT(IDLE_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .freeze(down),
    .wdata(reg_wr_data), .rd_data(reg_rd_data), .idle_bit(idle_bit)
  );

  pdn_seq_guard #(
    .DATA_W(DATA_W), .ARM_BIT(ARM_BIT), .START_BIT(START_BIT)
  ) u_guard (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .wr_en(reg_wr_en),
    .wdata(reg_wr_data), .pin_n(pd_allow_n), .down_o(down)
  );

  pdn_out_hold #(.ALT_W(ALT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .down(down),
    .clk_src(clk_out_src), .ale_src(ale_src), .psen_src(psen_src), .alt_src(alt_src),
    .clk_out(clk_out), .ale_out(ale_out), .psen_out(psen_out), .alt_out(alt_out)
  );

  assign osc_stop    = down;
  assign idle_active = (idle_bit || idle_req) && !down;

  AST_SLEEP_BEATS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> !idle_active); // R6
endmodule

// File: tb/pdn_ctrl_tb.sv
module pdn_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_done = 1'b0, reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic pd_allow_n = 1'b0, idle_req = 1'b0;
  logic clk_out_src = 1'b1, ale_src = 1'b1, psen_src = 1'b1;
  logic [3:0] alt_src = 4'h0;
  logic osc_stop, idle_active, clk_out, ale_out, psen_out;
  logic [3:0] alt_out;
  int n_total = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pdn_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .pd_allow_n(pd_allow_n),
    .idle_req(idle_req), .clk_out_src(clk_out_src), .ale_src(ale_src),
    .psen_src(psen_src), .alt_src(alt_src), .osc_stop(osc_stop),
    .idle_active(idle_active), .clk_out(clk_out), .ale_out(ale_out),
    .psen_out(psen_out), .alt_out(alt_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_store(input logic [7:0] v);
    @(negedge clk);
    insn_done = 1'b1; reg_wr_en = 1'b1; reg_wr_data = v;
    @(negedge clk);
    insn_done = 1'b0; reg_wr_en = 1'b0;
  endtask

  task automatic do_plain_insn();
    @(negedge clk);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    do_reset();
    chk("R10 reset rd", reg_rd_data, 8'h00);
    chk("R10 reset osc_stop", osc_stop, 0);
    chk("R8 pass-through before sleep", {clk_out, ale_out, psen_out}, 3'b111);

    // R1/R3: sweep first store, then start-only store
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      do_reset();
      do_store(b);
      do_store(8'h40);
      chk("R1_R3 first-slot sweep", osc_stop, (b[1] && !b[6]) ? 1 : 0);
    end

    // R1: sweep second store after a valid arm
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      do_reset();
      do_store(8'h02);
      do_store(b);
      chk("R1 second-slot sweep", osc_stop, (b[6] && !b[1]) ? 1 : 0);
    end

    // R4: readback masking over all values (pin high so no sleep)
    do_reset();
    pd_allow_n = 1'b1;
    for (int v = 0; v < 256; v++) begin
      do_store(v[7:0]);
      chk("R4 readback", reg_rd_data, v[7:0] & 8'hBD);
    end
    chk("R5 pin high kept awake through sweep", osc_stop, 0);
    pd_allow_n = 1'b0;

    // R3: combined store does not arm
    do_reset();
    do_store(8'h42);
    do_store(8'h40);
    chk("R3 both-set store does not arm", osc_stop, 0);

    // R2: intervening instruction disarms
    do_reset();
    do_store(8'h02); do_plain_insn(); do_store(8'h40);
    chk("R2 plain instruction disarms", osc_stop, 0);
    do_reset();
    do_store(8'h02); do_store(8'h01); do_store(8'h40);
    chk("R2 non-start store disarms", osc_stop, 0);
    do_reset();
    do_store(8'h02);
    repeat (3) @(negedge clk);
    do_store(8'h40);
    chk("R2 non-retire cycles keep arming", osc_stop, 1);

    // R5: pin high at either store blocks entry
    do_reset();
    pd_allow_n = 1'b1; do_store(8'h02); pd_allow_n = 1'b0; do_store(8'h40);
    chk("R5 pin high at arm", osc_stop, 0);
    do_reset();
    do_store(8'h02); pd_allow_n = 1'b1; do_store(8'h40); pd_allow_n = 1'b0;
    chk("R5 pin high at start", osc_stop, 0);

    // R6: idle arbitration
    do_reset();
    idle_req = 1'b1; @(negedge clk);
    chk("R6 external idle granted", idle_active, 1);
    idle_req = 1'b0; @(negedge clk);
    chk("R6 idle dropped", idle_active, 0);
    do_store(8'h01);
    chk("R6 register idle granted", idle_active, 1);
    idle_req = 1'b1;
    alt_src = 4'hA;
    do_store(8'h03);
    do_store(8'h41);
    alt_src = 4'h5;
    @(negedge clk);
    chk("R6 sleep wins over idle", idle_active, 0);
    chk("R1 entered with idle bits", osc_stop, 1);
    idle_req = 1'b0;

    // R8/R9: output forcing and holding
    chk("R8 strobes forced low", {clk_out, ale_out, psen_out}, 3'b000);
    chk("R9 alt held from start cycle", alt_out, 4'hA);
    alt_src = 4'h3; @(negedge clk);
    chk("R9 alt still held", alt_out, 4'hA);

    // R7: stores ignored, stays asleep
    do_store(8'h3C);
    chk("R7 store ignored in sleep", reg_rd_data, 8'h01);
    repeat (5) @(negedge clk);
    chk("R7 still asleep", osc_stop, 1);

    // R10: reset exits
    do_reset();
    chk("R10 reset exits sleep", osc_stop, 0);
    chk("R10 reset clears register", reg_rd_data, 8'h00);
    chk("R9 alt follows after reset", alt_out, 4'h3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule